// File: doc/BRIEF.md
# SPI Flash Command Frame Checker

This block watches the chip-select, serial-clock and serial-data-in pins of an SPI mode-0 flash port and judges each command frame. All three pins are sampled through synchronizer chains into the system clock. A rising serial clock edge seen while chip select is low shifts one bit in, most significant bit first. The first full byte of a frame becomes the opcode. The block counts how many whole bytes have arrived and keeps track of the bit position inside the current byte.

When chip select returns high, the block issues one single-cycle strobe in the system clock domain. An execute strobe commits the command. A reject strobe discards it. Commands that modify the device are committed only when the frame ends on a whole-byte boundary. Read-type commands carry a data-out phase, so they are flagged as such and may end at any bit. Downstream logic uses the opcode, the byte count and the strobes to drive the array model and the output driver; those parts are not part of this block.

Top module: `spi_frame_judge`

## Requirements
- R1: After reset, `opcode`, `byte_cnt`, `data_out_frame`, `exec_pulse` and `reject_pulse` are all zero.
- R2: The first eight serial clock rising edges after chip select falls form `opcode`, with the first bit as bit 7. The opcode holds until the next falling edge of chip select, which clears it to zero.
- R3: `byte_cnt` is cleared when chip select falls and rises by one for every eighth serial clock rising edge. It saturates at 2^CNT_W-1.
- R4: The write-type opcodes are 8'h06, 8'h04, 8'h01, 8'h02, 8'h20, 8'hD8, 8'hC7, 8'h60 and 8'hB9. A frame with one of these opcodes produces exactly one `exec_pulse` and no `reject_pulse` when chip select rises after a number of clock edges that is a multiple of 8.
- R5: A write-type frame that ends with a partial trailing byte produces exactly one `reject_pulse` and no `exec_pulse`.
- R6: The read-type opcodes are 8'h03, 8'h0B, 8'h05, 8'hAB and 8'h9F. Once the opcode byte of one of these completes, `data_out_frame` is 1. At chip select rise the frame produces exactly one `exec_pulse`, whatever the bit count.
- R7: A frame that ends before the opcode byte is complete produces neither pulse, and leaves `opcode` and `byte_cnt` at zero.
- R8: A frame whose complete opcode is in neither class produces exactly one `reject_pulse` and leaves `data_out_frame` at 0.
- R9: `exec_pulse` and `reject_pulse` are each one system clock cycle wide and are never high together.
- R10: Serial clock edges while chip select is high change neither `opcode` nor `byte_cnt`, and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select pin, active low |
| spi_sck | input | 1 | Serial clock pin |
| spi_mosi | input | 1 | Serial data in pin |
| opcode | output | 8 | Captured command byte |
| byte_cnt | output | CNT_W | Complete bytes received in the current frame |
| data_out_frame | output | 1 | The current frame carries a read-type opcode |
| exec_pulse | output | 1 | One-cycle strobe: commit the command |
| reject_pulse | output | 1 | One-cycle strobe: discard the command |

## Verification
The bench builds the block with CNT_W set to 4, so the byte counter saturates at 15. A 20-byte program frame can therefore reach the saturation limit, while an exact byte boundary is kept so that it still commits. SYNC_STAGES stays at 2. With that setting, an serial clock half period of four system cycles keeps every edge separately visible, and the pulse window after chip select rise covers the full synchronizer latency.

// File: rtl/spi_frame_judge.sv
module spi_frame_judge #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             spi_sck,
  input  logic             spi_mosi,
  output logic [7:0]       opcode,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             data_out_frame,
  output logic             exec_pulse,
  output logic             reject_pulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] cs_sync, sck_sync, mosi_sync;
  logic       cs_q, sck_q;
  logic [6:0] shift;
  logic [2:0] bit_cnt;
  logic       wr_cls, rd_cls;

  wire cs_now   = cs_sync[SYNC_STAGES-1];
  wire sck_now  = sck_sync[SYNC_STAGES-1];
  wire mosi_now = mosi_sync[SYNC_STAGES-1];
  wire cs_fall  = cs_q & ~cs_now;
  wire cs_rise  = ~cs_q & cs_now;
  wire sck_rise = sck_now & ~sck_q & ~cs_now;
  wire [7:0] next_byte = {shift, mosi_now};

  function automatic logic is_write(input logic [7:0] op);
    case (op)
      8'h06, 8'h04, 8'h01, 8'h02, 8'h20, 8'hD8, 8'hC7, 8'h60, 8'hB9: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_read(input logic [7:0] op);
    case (op)
      8'h03, 8'h0B, 8'h05, 8'hAB, 8'h9F: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  assign data_out_frame = rd_cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync   <= '1;
      sck_sync  <= '0;
      mosi_sync <= '0;
      cs_q      <= 1'b1;
      sck_q     <= 1'b0;
    end else begin
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], spi_cs_n};
      sck_sync  <= {sck_sync[SYNC_STAGES-2:0], spi_sck};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], spi_mosi};
      cs_q      <= cs_now;
      sck_q     <= sck_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift        <= '0;
      bit_cnt      <= '0;
      byte_cnt     <= '0;
      opcode       <= '0;
      wr_cls       <= 1'b0;
      rd_cls       <= 1'b0;
      exec_pulse   <= 1'b0;
      reject_pulse <= 1'b0;
    end else begin
      exec_pulse   <= 1'b0;
      reject_pulse <= 1'b0;
      if (cs_fall) begin
        shift    <= '0;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        opcode   <= '0;
        wr_cls   <= 1'b0;
        rd_cls   <= 1'b0;
      end else if (sck_rise) begin
        shift   <= next_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
          if (byte_cnt == '0) begin
            opcode <= next_byte;
            wr_cls <= is_write(next_byte);
            rd_cls <= is_read(next_byte);
          end
        end
      end
      if (cs_rise && byte_cnt != '0) begin
        if (rd_cls || (wr_cls && bit_cnt == 3'd0)) exec_pulse <= 1'b1;
        else reject_pulse <= 1'b1;
      end
    end
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_pulse && reject_pulse));
  p_exec_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse |=> !exec_pulse);
  p_rej_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reject_pulse |=> !reject_pulse);
  p_no_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_pulse || reject_pulse) |-> $past(byte_cnt) != '0);
  p_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_pulse && $past(wr_cls)) |-> $past(bit_cnt) == 3'd0);
  p_dof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_out_frame |-> byte_cnt != '0);
  p_opc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(byte_cnt) != '0 && byte_cnt != '0) |-> $stable(opcode));
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_cnt != $past(byte_cnt)) |-> (byte_cnt == '0 || byte_cnt == $past(byte_cnt) + 1'b1));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_now) |-> ($stable(byte_cnt) && $stable(opcode)));

endmodule

// File: tb/spi_frame_judge_bench.sv
module spi_frame_judge_bench;
  localparam int CNT_W = 4;
  localparam int HALF  = 4;
  localparam int NV    = 21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic [7:0] opcode;
  logic [CNT_W-1:0] byte_cnt;
  logic dof, exec_p, rej_p;
  int n_chk = 0, n_bad = 0;
  int n_exec, n_rej;

  always #10 clk = ~clk;

  spi_frame_judge #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_spi_frame_judge (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .opcode(opcode), .byte_cnt(byte_cnt), .data_out_frame(dof),
    .exec_pulse(exec_p), .reject_pulse(rej_p));

  // {opcode, clock count, expect exec, expect reject, expect data-out}
  localparam logic [20:0] VEC [NV] = '{
    {8'h06, 10'd8,  3'b100},  // R4
    {8'h06, 10'd12, 3'b010},  // R5
    {8'h02, 10'd40, 3'b100},  // R4
    {8'h02, 10'd37, 3'b010},  // R5
    {8'h20, 10'd32, 3'b100},  // R4
    {8'hC7, 10'd8,  3'b100},  // R4
    {8'h60, 10'd9,  3'b010},  // R5
    {8'h01, 10'd16, 3'b100},  // R4
    {8'h04, 10'd8,  3'b100},  // R4
    {8'hB9, 10'd15, 3'b010},  // R5
    {8'hD8, 10'd32, 3'b100},  // R4
    {8'h03, 10'd8,  3'b101},  // R6
    {8'h03, 10'd29, 3'b101},  // R6
    {8'h0B, 10'd45, 3'b101},  // R6
    {8'h05, 10'd13, 3'b101},  // R6
    {8'hAB, 10'd8,  3'b101},  // R6
    {8'h9F, 10'd27, 3'b101},  // R6
    {8'h5A, 10'd16, 3'b010},  // R8
    {8'h00, 10'd8,  3'b010},  // R8
    {8'h06, 10'd5,  3'b000},  // R7
    {8'hFF, 10'd3,  3'b000}   // R7
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] op, input int nbits);
    logic [7:0] pat;
    pat = 8'hA5;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 8) ? op[7 - i] : pat[7 - ((i - 8) % 8)];
      sck = 1'b0;
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
    end
    sck = 1'b0;
    wait_clk(2 * HALF);
  endtask

  task automatic close_frame();
    n_exec = 0;
    n_rej = 0;
    cs_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      n_exec += int'(exec_p);
      n_rej  += int'(rej_p);
    end
  endtask

  initial begin
    #4000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_clk(3);
    chk("R1 opcode", opcode, 0);
    chk("R1 byte_cnt", byte_cnt, 0);
    chk("R1 pulses", {dof, exec_p, rej_p}, 0);
    rst_n = 1'b1;
    wait_clk(4);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] op;
      int nb, eb;
      op = VEC[v][20:13];
      nb = int'(VEC[v][12:3]);
      eb = nb / 8;
      frame(op, nb);
      chk("R2 opcode", opcode, (nb >= 8) ? int'(op) : 0);
      chk("R3 byte_cnt", byte_cnt, eb);
      chk("R6 data_out_frame", dof, int'(VEC[v][0]));
      close_frame();
      chk("R4/R5/R6/R7/R8 exec count", n_exec, int'(VEC[v][2]));
      chk("R4/R5/R6/R7/R8 reject count", n_rej, int'(VEC[v][1]));
      wait_clk(4);
    end

    // R3 saturation: 20 whole bytes with a counter that tops out at 15
    frame(8'h02, 160);
    chk("R3 saturated byte_cnt", byte_cnt, 15);
    close_frame();
    chk("R4 exec after saturation", n_exec, 1);
    chk("R9 exclusive pulses", n_rej, 0);

    // R10 clocks with chip select high
    frame(8'h9F, 16);
    close_frame();
    for (int i = 0; i < 10; i++) begin
      mosi = i[0];
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
      wait_clk(HALF);
    end
    chk("R10 opcode kept", opcode, 8'h9F);
    chk("R10 byte_cnt kept", byte_cnt, 2);
    n_exec = 0;
    n_rej = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      n_exec += int'(exec_p);
      n_rej  += int'(rej_p);
    end
    chk("R10 no pulse", n_exec + n_rej, 0);

    // R2 next frame clears the previous opcode
    cs_n = 1'b0;
    wait_clk(8);
    chk("R2 opcode cleared", opcode, 0);
    chk("R3 byte_cnt cleared", byte_cnt, 0);
    cs_n = 1'b1;
    wait_clk(8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule